// File: doc/BRIEF.md
# I/O-Port Block-Transfer Command Decoder

This block sits on a 16-bit processor I/O bus and converts a short sequence of port writes into a block-transfer request for an SDRAM sequencer. Two I/O ports assemble a 21-bit SDRAM address from a 16-bit low part and a 5-bit high part. A third port takes a command word whose bit 0 selects the direction and whose arrival starts a transfer of one 128-byte block. The block answers with a one-cycle start strobe, the assembled address, a direction flag, an address-reset strobe for the sequencer's own counters and a ready flag that the processor polls.

Two 128-byte buffers sit between the processor and the SDRAM, used in turns: the processor works on one while the sequencer works on the other. The bank-select output picks which buffer the processor side currently owns. To write, the processor fills its buffer byte by byte, loads the address and issues a write command. The buffers swap at once, so the sequencer drains the filled one. To read, it loads the address and issues a read command. The buffers swap when the sequencer reports completion, and the processor then reads the fetched block. Processor byte accesses to the data window are steered to the buffer through a 7-bit auto-incrementing address counter. The counter restarts at zero with every accepted command.

Top module: `dcd_top`

## Requirements
- R1: After reset, rdy_o is 1, and xfer_start_o, addr_rst_o, bank_sel_o, xfer_wr_o, xfer_addr_o and the buffer address counter are all 0.
- R2: An I/O write (io_sel_i=1, io_we_i=1) to port 0x04 loads io_wdata_i[15:0] into xfer_addr_o[15:0], visible one cycle later. Bits 20:16 are left unchanged.
- R3: An I/O write to port 0x03 loads io_wdata_i[4:0] into xfer_addr_o[20:16], visible one cycle later. io_wdata_i[15:5] are ignored and bits 15:0 are left unchanged.
- R4: An I/O write to port 0x05 while rdy_o=1 produces, in the next cycle, exactly one cycle of xfer_start_o=1 and of addr_rst_o=1. In that same cycle rdy_o goes to 0 and xfer_wr_o takes io_wdata_i[0] (1 = write to SDRAM, 0 = read from SDRAM).
- R5: seq_done_i=1 while rdy_o=0 sets rdy_o to 1 one cycle later. seq_done_i while rdy_o=1 has no effect.
- R6: A write to port 0x05 while rdy_o=0 is ignored: no start strobe, no address-reset strobe, and no change to xfer_wr_o or bank_sel_o.
- R7: bank_sel_o toggles in the same cycle as the start strobe of a write command, and in the same cycle rdy_o rises after a read command. It changes at no other time.
- R8: A data-window access (mem_sel_i=1) updates the buffer outputs one cycle later. buf_addr_o takes the counter value and the counter then advances by 1 modulo 128. A write (mem_we_i=1) gives a one-cycle buf_wstb_o, sets buf_we_o=1 and copies mem_wdata_i to buf_wdata_o. A read gives a one-cycle buf_rstb_o and sets buf_we_o=0.
- R9: The address-reset strobe clears the buffer counter, so the first data-window access after an accepted command uses buffer address 0.
- R10: I/O reads (io_we_i=0) and I/O writes to any port other than 0x03, 0x04 and 0x05 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 1 | I/O bus cycle valid |
| io_we_i | input | 1 | I/O cycle is a write |
| io_addr_i | input | 8 | I/O port number |
| io_wdata_i | input | 16 | I/O write data |
| mem_sel_i | input | 1 | Data-window byte access valid |
| mem_we_i | input | 1 | Data-window access is a write |
| mem_wdata_i | input | 8 | Data-window write byte |
| seq_done_i | input | 1 | Sequencer finished the block transfer |
| rdy_o | output | 1 | Ready for a new command |
| xfer_start_o | output | 1 | One-cycle transfer start strobe |
| xfer_wr_o | output | 1 | Direction: 1 = to SDRAM, 0 = from SDRAM |
| xfer_addr_o | output | 21 | SDRAM block address |
| addr_rst_o | output | 1 | One-cycle address-counter reset strobe |
| bank_sel_o | output | 1 | Buffer owned by the processor side |
| buf_wstb_o | output | 1 | Buffer write strobe |
| buf_rstb_o | output | 1 | Buffer read strobe |
| buf_we_o | output | 1 | Buffer access direction, 1 = write |
| buf_addr_o | output | 7 | Buffer byte address |
| buf_wdata_o | output | 8 | Buffer write byte |

## Verification
A stuck or mis-reset ready flag shows at the next command. Either no start strobe appears one cycle after a write to port 0x05, or a second strobe appears while a transfer is pending. A bank-select flag out of step with the transfer direction shows as a wrong bank_sel_o in the cycle of the start strobe or of the ready rise, so the processor would fill or read the wrong buffer. A counter that is not cleared or wraps wrongly shows on buf_addr_o at the first data-window access after a command, or at the 129th access of a sweep.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int unsigned IOA_W = 8;
  typedef logic [IOA_W-1:0] ioa_t;
  localparam ioa_t PORT_HI  = 8'h03;
  localparam ioa_t PORT_LO  = 8'h04;
  localparam ioa_t PORT_CMD = 8'h05;
  typedef enum logic {XF_READ = 1'b0, XF_WRITE = 1'b1} xfer_dir_e;
endpackage

// File: rtl/dcd_port_regs.sv
module dcd_port_regs #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned LO_W   = 16,
  parameter int unsigned IO_DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [IO_DW-1:0]  wdata_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
    end else begin
      if (ld_lo_i) addr_o[LO_W-1:0]      <= wdata_i[LO_W-1:0];
      if (ld_hi_i) addr_o[ADDR_W-1:LO_W] <= wdata_i[HI_W-1:0];
    end
  end
endmodule

// File: rtl/dcd_xfer_ctl.sv
module dcd_xfer_ctl
  import dcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic cmd_wr_i,
  input  logic done_i,
  output logic start_o,
  output logic addr_rst_o,
  output logic rdy_o,
  output logic dir_o,
  output logic bank_o
);
  logic accept, finish;
  assign accept = cmd_i & rdy_o;
  assign finish = done_i & ~rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o    <= 1'b0;
      addr_rst_o <= 1'b0;
      rdy_o      <= 1'b1;
      dir_o      <= XF_READ;
      bank_o     <= 1'b0;
    end else begin
      start_o    <= accept;
      addr_rst_o <= accept;
      if (accept) begin
        rdy_o <= 1'b0;
        dir_o <= cmd_wr_i;
        // filled buffer goes to the sequencer at once
        if (cmd_wr_i == XF_WRITE) bank_o <= ~bank_o;
      end else if (finish) begin
        rdy_o <= 1'b1;
        // fetched block handed over only once complete
        if (dir_o == XF_READ) bank_o <= ~bank_o;
      end
    end
  end
endmodule

// File: rtl/dcd_buf_steer.sv
module dcd_buf_steer #(
  parameter int unsigned BUF_AW = 7,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic              wstb_o,
  output logic              rstb_o,
  output logic              we_o,
  output logic [BUF_AW-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  logic [BUF_AW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (clr_i)  cnt <= '0;
    else if (acc_i)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wstb_o  <= 1'b0;
      rstb_o  <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      wstb_o <= acc_i & we_i;
      rstb_o <= acc_i & ~we_i;
      if (acc_i) begin
        we_o   <= we_i;
        addr_o <= cnt;
        if (we_i) wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dcd_top.sv
module dcd_top
  import dcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned LO_W   = 16,
  parameter int unsigned IO_DW  = 16,
  parameter int unsigned BUF_AW = 7,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              io_we_i,
  input  logic [IOA_W-1:0]  io_addr_i,
  input  logic [IO_DW-1:0]  io_wdata_i,
  input  logic              mem_sel_i,
  input  logic              mem_we_i,
  input  logic [BYTE_W-1:0] mem_wdata_i,
  input  logic              seq_done_i,
  output logic              rdy_o,
  output logic              xfer_start_o,
  output logic              xfer_wr_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              addr_rst_o,
  output logic              bank_sel_o,
  output logic              buf_wstb_o,
  output logic              buf_rstb_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [BYTE_W-1:0] buf_wdata_o
);
  logic io_wr, ld_hi, ld_lo, cmd;
  assign io_wr = io_sel_i & io_we_i;
  assign ld_hi = io_wr & (io_addr_i == PORT_HI);
  assign ld_lo = io_wr & (io_addr_i == PORT_LO);
  assign cmd   = io_wr & (io_addr_i == PORT_CMD);

  dcd_port_regs #(.ADDR_W(ADDR_W), .LO_W(LO_W), .IO_DW(IO_DW)) u_regs (
    .clk_i, .rst_ni,
    .ld_hi_i (ld_hi),
    .ld_lo_i (ld_lo),
    .wdata_i (io_wdata_i),
    .addr_o  (xfer_addr_o)
  );

  dcd_xfer_ctl u_ctl (
    .clk_i, .rst_ni,
    .cmd_i      (cmd),
    .cmd_wr_i   (io_wdata_i[0]),
    .done_i     (seq_done_i),
    .start_o    (xfer_start_o),
    .addr_rst_o (addr_rst_o),
    .rdy_o      (rdy_o),
    .dir_o      (xfer_wr_o),
    .bank_o     (bank_sel_o)
  );

  dcd_buf_steer #(.BUF_AW(BUF_AW), .BYTE_W(BYTE_W)) u_steer (
    .clk_i, .rst_ni,
    .acc_i   (mem_sel_i),
    .we_i    (mem_we_i),
    .wdata_i (mem_wdata_i),
    .clr_i   (addr_rst_o),
    .wstb_o  (buf_wstb_o),
    .rstb_o  (buf_rstb_o),
    .we_o    (buf_we_o),
    .addr_o  (buf_addr_o),
    .wdata_o (buf_wdata_o)
  );
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
#(
  parameter int unsigned BUF_AW = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_sel_i,
  input logic              io_we_i,
  input logic [IOA_W-1:0]  io_addr_i,
  input logic              seq_done_i,
  input logic              rdy_o,
  input logic              xfer_start_o,
  input logic              xfer_wr_o,
  input logic              addr_rst_o,
  input logic              bank_sel_o,
  input logic              buf_wstb_o,
  input logic              buf_rstb_o,
  input logic [BUF_AW-1:0] buf_addr_o
);
  logic cmd_wr;
  assign cmd_wr = io_sel_i & io_we_i & (io_addr_i == PORT_CMD);

  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> !rdy_o);
  a_r5_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && seq_done_i) |=> rdy_o);
  a_r6_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && cmd_wr) |=> (!xfer_start_o && $stable(xfer_wr_o)));
  a_r7_write_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_o && xfer_wr_o) |-> (bank_sel_o != $past(bank_sel_o)));
  a_r7_bank_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_o && !$rose(rdy_o)) |-> $stable(bank_sel_o));
  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_wstb_o, buf_rstb_o}));
  a_r9_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((buf_wstb_o || buf_rstb_o) && $past(addr_rst_o, 2) && !$past(addr_rst_o))
      |-> (buf_addr_o == '0));
endmodule

bind dcd_top dcd_checker #(.BUF_AW(BUF_AW)) u_dcd_checker (
  .clk_i, .rst_ni, .io_sel_i, .io_we_i, .io_addr_i, .seq_done_i,
  .rdy_o, .xfer_start_o, .xfer_wr_o, .addr_rst_o, .bank_sel_o,
  .buf_wstb_o, .buf_rstb_o, .buf_addr_o
);

// File: tb/dcd_top_bench.sv
`timescale 1ns/1ps
module dcd_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sel = 1'b0, io_we = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic        mem_sel = 1'b0, mem_we = 1'b0;
  logic [7:0]  mem_wdata = '0;
  logic        seq_done = 1'b0;
  logic        rdy, start, xwr, arst, bank, wstb, rstb, bwe;
  logic [20:0] xaddr;
  logic [6:0]  baddr;
  logic [7:0]  bwdata;

  int nchk = 0, nerr = 0;
  int exp_cnt = 0;
  logic exp_bank = 1'b0;
  logic [20:0] exp_addr = '0;

  always #4 clk = ~clk;

  dcd_top u_dcd_top (
    .clk_i(clk), .rst_ni(rst_n), .io_sel_i(io_sel), .io_we_i(io_we),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .mem_sel_i(mem_sel),
    .mem_we_i(mem_we), .mem_wdata_i(mem_wdata), .seq_done_i(seq_done),
    .rdy_o(rdy), .xfer_start_o(start), .xfer_wr_o(xwr), .xfer_addr_o(xaddr),
    .addr_rst_o(arst), .bank_sel_o(bank), .buf_wstb_o(wstb), .buf_rstb_o(rstb),
    .buf_we_o(bwe), .buf_addr_o(baddr), .buf_wdata_o(bwdata)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic io_cyc(input logic we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_we = we; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_sel = 1'b0; io_we = 1'b0;
  endtask

  task automatic mem_cyc(input logic we, input logic [7:0] d);
    @(negedge clk);
    mem_sel = 1'b1; mem_we = we; mem_wdata = d;
    @(negedge clk);
    mem_sel = 1'b0;
    chk("R8 wstb", wstb, we);
    chk("R8 rstb", rstb, !we);
    chk("R8 we", bwe, we);
    chk("R8 addr", baddr, exp_cnt % 128);
    if (we) chk("R8 wdata", bwdata, d);
    exp_cnt = (exp_cnt + 1) % 128;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  // command while ready, checked through completion
  task automatic run_cmd(input logic [15:0] w);
    logic dir;
    dir = w[0];
    io_cyc(1'b1, 8'h05, w);
    if (dir) exp_bank = ~exp_bank;
    chk("R4 start", start, 1);
    chk("R4 addr_rst", arst, 1);
    chk("R4 rdy low", rdy, 0);
    chk("R4 dir", xwr, dir);
    chk("R7 bank at start", bank, exp_bank);
    exp_cnt = 0;
    @(negedge clk);
    chk("R4 start single", start, 0);
    chk("R4 addr_rst single", arst, 0);
    io_cyc(1'b1, 8'h05, {w[15:1], ~dir});
    chk("R6 busy no start", start, 0);
    chk("R6 busy no addr_rst", arst, 0);
    chk("R6 busy dir kept", xwr, dir);
    chk("R6 busy bank kept", bank, exp_bank);
    mem_cyc(1'b1, w[7:0]);          // R9: first access at 0
    chk("R9 counter cleared", exp_cnt, 1);
    done_pulse();
    if (!dir) exp_bank = ~exp_bank;
    chk("R5 rdy rises", rdy, 1);
    chk("R7 bank at done", bank, exp_bank);
    done_pulse();
    chk("R5 idle done ignored rdy", rdy, 1);
    chk("R5 idle done ignored bank", bank, exp_bank);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 rdy", rdy, 1);
    chk("R1 start", start, 0);
    chk("R1 addr_rst", arst, 0);
    chk("R1 bank", bank, 0);
    chk("R1 dir", xwr, 0);
    chk("R1 addr", xaddr, 0);

    // R2 low-part sweep
    for (int i = 0; i < 256; i++) begin
      logic [15:0] v;
      v = 16'(i * 257) ^ 16'(i << 3) ^ 16'hA5C3;
      io_cyc(1'b1, 8'h04, v);
      exp_addr[15:0] = v;
      chk("R2 low load", xaddr, exp_addr);
    end
    // R3 high-part sweep with junk upper bits
    for (int h = 0; h < 32; h++) begin
      logic [15:0] v;
      v = {11'(h * 37 + 5), 5'(h)};
      io_cyc(1'b1, 8'h03, v);
      exp_addr[20:16] = 5'(h);
      chk("R3 high load", xaddr, exp_addr);
    end
    // R10 reads and foreign ports
    for (int p = 0; p < 16; p++) begin
      io_cyc(1'b0, 8'(p), 16'hFFFF);
      chk("R10 read no addr change", xaddr, exp_addr);
      chk("R10 read no start", start, 0);
      if (p != 3 && p != 4 && p != 5) begin
        io_cyc(1'b1, 8'(p), 16'h5A5B);
        chk("R10 foreign addr", xaddr, exp_addr);
        chk("R10 foreign start", start, 0);
        chk("R10 foreign rdy", rdy, 1);
        chk("R10 foreign bank", bank, exp_bank);
      end
    end
    io_cyc(1'b1, 8'h85, 16'h0001);
    chk("R10 aliased port no start", start, 0);

    // R8 sweep across the wrap
    for (int k = 0; k < 300; k++) mem_cyc(k[0], 8'(k * 7 + 1));

    // R4-R7, R9 for several command words
    run_cmd(16'h0001);
    run_cmd(16'h0000);
    run_cmd(16'hFFFF);
    run_cmd(16'hFFFE);
    run_cmd(16'h0001);
    run_cmd(16'h0001);
    run_cmd(16'h1230);
    chk("R2 addr held across transfers", xaddr, exp_addr);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule